// File: doc/BRIEF.md
# Wired-AND Address Arbiter

This block is the arbitration front end of one node on a shared open-drain bus. Any node may pull the shared line low, and a released line reads high. To claim the bus, a node places its own address on the line one bit per clock, most significant bit first. It pulls the line low for a 0 bit and releases it for a 1 bit. While it does so, the node samples the resolved line. If it released the line but reads it low, a node with a smaller address is also contending. The node then drops out and releases the line for the rest of the contest.

No central arbiter is involved. The contender with the numerically smallest address always reads back exactly what it drove, so it completes its address and raises `won` for one cycle. A node that drops out raises `lost`. It accepts no new start request until the line has been read high for a set number of consecutive cycles.

Top module: `wiredAndArbiter`

## Requirements
- R1: After reset, `won` and `lost` are 0 and `busOut` is 1, which means the line is released.
- R2: A `startArb` sampled while the node is idle latches `nodeAddr`. From the next cycle, `busOut` carries the address bits most significant bit first, one per cycle, for ADDR_W cycles. `busOut` is 0 for a 0 bit and 1 for a 1 bit.
- R3: If the node drives 1 and samples `busIn` at 0 on the same clock edge, `lost` is 1 from the next cycle. `busOut` stays 1 for as long as `lost` is 1.
- R4: If all ADDR_W bits are sent without a loss, `won` is 1 for exactly one cycle, in the cycle after the last address bit.
- R5: When two nodes with different addresses start together, the smaller address wins and the other node loses. This includes addresses that differ only in the least significant bit.
- R6: `lost` stays 1 until `busIn` has been sampled high on IDLE_CYC consecutive edges (default 4). Any low sample restarts the count.
- R7: `startArb` has no effect while `lost` is 1. `busOut` stays 1 and `won` stays 0.
- R8: `startArb` has no effect while the address is being sent. The contest continues with the address latched at its start.
- R9: `won` and `lost` are never 1 in the same cycle.
- R10: A node that contends alone raises `won` ADDR_W+1 cycles after its start request is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startArb | input | 1 | Request to begin an arbitration |
| nodeAddr | input | ADDR_W | This node's address, latched at start |
| busIn | input | 1 | Resolved wired-AND line level |
| busOut | output | 1 | Level this node puts on the line (1 = released) |
| won | output | 1 | One-cycle pulse: arbitration won |
| lost | output | 1 | High from a loss until the line has been idle long enough |

## Verification
Two events can land on the same clock edge: the last address bit, which would end in a win, and a loss. Contests between addresses that differ only in the least significant bit (for example 4 against 5) make the losing node detect its loss on the edge that would otherwise produce `won`. The bench requires `lost` and no `won` pulse there. A second collision is between the end of the back-off wait and a start request. This is provoked by holding `startArb` high through the whole back-off. The bench expects the request to be ignored on the edge where `lost` clears and accepted on the following edge. A behavioural model of the rival node and of the requirements predicts every cycle.

// File: rtl/arbPkg.sv
package arbPkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ARB     = 2'd1,
    ST_BACKOFF = 2'd2
  } arbState_t;

  typedef struct packed {
    logic loadAddr;
    logic stepBit;
    logic clrIdle;
    logic incIdle;
  } arbStrobe_t;

endpackage

// File: rtl/arbDatapath.sv
module arbDatapath
  import arbPkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int IDLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  arbStrobe_t        ctl,
  input  logic [ADDR_W-1:0] nodeAddr,
  input  logic              busIn,
  output logic              curBit,
  output logic              lastBit,
  output logic              idleDone
);

  localparam int IDX_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;
  localparam int CNT_W = (IDLE_CYC > 1) ? $clog2(IDLE_CYC + 1) : 1;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IDLE_CYC - 1);

  logic [ADDR_W-1:0] addrReg;
  logic [IDX_W-1:0]  bitIdx;
  logic [CNT_W-1:0]  idleCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      bitIdx  <= '0;
    end else if (ctl.loadAddr) begin
      addrReg <= nodeAddr;
      bitIdx  <= TOP_IDX;
    end else if (ctl.stepBit) begin
      bitIdx <= bitIdx - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clrIdle) begin
      idleCnt <= '0;
    end else if (ctl.incIdle) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  assign curBit   = addrReg[bitIdx];
  assign lastBit  = (bitIdx == '0);
  assign idleDone = busIn && (idleCnt == CNT_LAST);

  // R2: control never steps beyond the least significant bit
  assert_no_step_past_lsb_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stepBit |-> (bitIdx != '0));

  // R6: idle counter stays within the configured window
  assert_idle_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    idleCnt < CNT_W'(IDLE_CYC));

  // R2: a step moves exactly one bit toward the LSB
  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stepBit && !ctl.loadAddr) |=> (bitIdx == $past(bitIdx) - 1'b1));

endmodule

// File: rtl/arbControl.sv
module arbControl
  import arbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startArb,
  input  logic       busIn,
  input  logic       curBit,
  input  logic       lastBit,
  input  logic       idleDone,
  output arbStrobe_t ctl,
  output logic       busOut,
  output logic       won,
  output logic       lost
);

  arbState_t state, nextState;
  logic      wonNext;

  always_comb begin
    nextState = state;
    ctl       = '0;
    wonNext   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startArb) begin
          ctl.loadAddr = 1'b1;
          nextState    = ST_ARB;
        end
      end
      ST_ARB: begin
        if (curBit && !busIn) begin
          ctl.clrIdle = 1'b1;
          nextState   = ST_BACKOFF;
        end else if (lastBit) begin
          wonNext   = 1'b1;
          nextState = ST_IDLE;
        end else begin
          ctl.stepBit = 1'b1;
        end
      end
      ST_BACKOFF: begin
        if (!busIn) begin
          ctl.clrIdle = 1'b1;
        end else if (idleDone) begin
          ctl.clrIdle = 1'b1;
          nextState   = ST_IDLE;
        end else begin
          ctl.incIdle = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      won   <= 1'b0;
    end else begin
      state <= nextState;
      won   <= wonNext;
    end
  end

  assign busOut = (state == ST_ARB) ? curBit : 1'b1;
  assign lost   = (state == ST_BACKOFF);

  assert_won_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    won |=> !won);

  assert_won_lost_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(won && lost));

  assert_release_while_lost_R3: assert property (@(posedge clk) disable iff (!rstN)
    lost |-> busOut);

  assert_loss_detect_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARB && busOut && !busIn) |=> lost);

  assert_hold_on_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    (lost && !busIn) |=> lost);

  assert_exit_after_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lost) |-> $past(busIn));

  assert_no_win_from_backoff_R7: assert property (@(posedge clk) disable iff (!rstN)
    lost |=> !won);

endmodule

// File: rtl/wiredAndArbiter.sv
module wiredAndArbiter
  import arbPkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int IDLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startArb,
  input  logic [ADDR_W-1:0] nodeAddr,
  input  logic              busIn,
  output logic              busOut,
  output logic              won,
  output logic              lost
);

  arbStrobe_t ctl;
  logic curBit, lastBit, idleDone;

  arbDatapath #(.ADDR_W(ADDR_W), .IDLE_CYC(IDLE_CYC)) uDatapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .nodeAddr(nodeAddr), .busIn(busIn),
    .curBit(curBit), .lastBit(lastBit), .idleDone(idleDone)
  );

  arbControl uControl (
    .clk(clk), .rstN(rstN), .startArb(startArb), .busIn(busIn),
    .curBit(curBit), .lastBit(lastBit), .idleDone(idleDone),
    .ctl(ctl), .busOut(busOut), .won(won), .lost(lost)
  );

endmodule

// File: tb/wiredAndArbiter_test.sv
`timescale 1ns/1ps
module wiredAndArbiter_test;

  localparam int AW   = 3;
  localparam int IDLE = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startArb = 1'b0;
  logic [AW-1:0] nodeAddr = '0;
  logic rivalLvl = 1'b1;
  logic busOut, won, lost, busLine;

  always #2 clk = ~clk;

  assign busLine = busOut & rivalLvl;

  wiredAndArbiter #(.ADDR_W(AW), .IDLE_CYC(IDLE)) uut (
    .clk(clk), .rstN(rstN), .startArb(startArb), .nodeAddr(nodeAddr),
    .busIn(busLine), .busOut(busOut), .won(won), .lost(lost)
  );

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  // reference model of the requirements
  int mSt = 0;          // 0 idle, 1 sending, 2 backing off
  logic [AW-1:0] mAddr = '0;
  int mIdx = 0;
  int mCnt = 0;
  logic mWon = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic expOut();
    return (mSt == 1) ? mAddr[mIdx] : 1'b1;
  endfunction

  // called at a negedge; returns at the next negedge
  task automatic step(input logic st, input logic [AW-1:0] a, input logic riv);
    logic bus;
    chk(busOut === expOut(), "R2 busOut", int'(busOut), int'(expOut()));
    chk(won === mWon, "R4 won", int'(won), int'(mWon));
    chk(lost === (mSt == 2), "R6 lost", int'(lost), int'(mSt == 2));
    chk(!(won && lost), "R9 exclusive", int'(won && lost), 0);
    startArb = st;
    nodeAddr = a;
    rivalLvl = riv;
    @(posedge clk);
    bus  = expOut() & riv;
    mWon = 1'b0;
    case (mSt)
      0: if (st) begin mSt = 1; mAddr = a; mIdx = AW - 1; end
      1: if (expOut() && !bus) begin mSt = 2; mCnt = 0; end
         else if (mIdx == 0) begin mSt = 0; mWon = 1'b1; end
         else mIdx--;
      default: if (!bus) mCnt = 0;
               else if (mCnt == IDLE - 1) begin mSt = 0; mCnt = 0; end
               else mCnt++;
    endcase
    @(negedge clk);
  endtask

  task automatic drain();
    while (mSt != 0) begin
      logic s;
      s = ($urandom_range(0, 3) == 0);
      step(s, AW'($urandom), ($urandom_range(0, 9) < 7));
      // R7: a request during back-off never yields a win
      chk(!won, "R7 no win in backoff", int'(won), 0);
    end
  endtask

  task automatic contest(input logic [AW-1:0] myA, input logic [AW-1:0] rivA,
                         input bit rivOn, input bit midStart);
    bit rivLost = 0;
    bit expWin;
    step(1'b1, myA, 1'b1);
    for (int k = 0; k < AW; k++) begin
      logic rivOut;
      logic bus;
      rivOut = (!rivOn || rivLost) ? 1'b1 : rivA[AW-1-k];
      bus = expOut() & rivOut;
      // R8: a request mid-contest with another address must be ignored
      step(midStart && k == 1, ~myA, rivOut);
      if (rivOut && !bus) rivLost = 1;
    end
    expWin = !rivOn || (myA < rivA);
    if (rivOn) begin
      chk(won === expWin, "R5 winner", int'(won), int'(expWin));
      chk(lost === !expWin, "R5 loser", int'(lost), int'(!expWin));
      if (!expWin) chk(busOut === 1'b1, "R3 released after loss", int'(busOut), 1);
    end else begin
      chk(won === 1'b1, "R10 lone node wins", int'(won), 1);
    end
    if (midStart) chk(won === expWin, "R8 start ignored", int'(won), int'(expWin));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    chk(0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state, before any start
    chk(won === 1'b0, "R1 won", int'(won), 0);
    chk(lost === 1'b0, "R1 lost", int'(lost), 0);
    chk(busOut === 1'b1, "R1 busOut", int'(busOut), 1);

    // R10: lone node, also R2 bit order via model
    contest(3'd6, 3'd0, 0, 0);
    step(1'b0, '0, 1'b1);
    chk(won === 1'b0, "R4 single pulse", int'(won), 0);

    // R5: LSB-only difference, win side and lose side
    contest(3'd4, 3'd5, 1, 0);
    drain();
    contest(3'd5, 3'd4, 1, 0);
    chk(won === 1'b0, "R5 LSB loss no win", int'(won), 0);
    drain();

    // R5 extremes with a mid-contest start (R8)
    contest(3'd0, 3'd7, 1, 1);
    drain();
    contest(3'd7, 3'd0, 1, 1);
    drain();

    // R6: a low sample restarts the idle count
    contest(3'd5, 3'd2, 1, 0);
    step(1'b0, '0, 1'b0);
    for (int i = 0; i < IDLE - 1; i++) step(1'b0, '0, 1'b1);
    chk(lost === 1'b1, "R6 held before window", int'(lost), 1);
    step(1'b0, '0, 1'b0);
    for (int i = 0; i < IDLE - 1; i++) step(1'b0, '0, 1'b1);
    chk(lost === 1'b1, "R6 count restarted", int'(lost), 1);
    step(1'b0, '0, 1'b1);
    chk(lost === 1'b0, "R6 released", int'(lost), 0);

    // R7: request held through back-off, accepted only after release
    contest(3'd3, 3'd1, 1, 0);
    while (mSt == 2) begin
      step(1'b1, 3'd2, 1'b1);
      if (mSt == 2) chk(busOut === 1'b1, "R7 released", int'(busOut), 1);
    end
    step(1'b1, 3'd2, 1'b1);
    chk(mSt == 1, "R7 accepted after release", mSt, 1);
    while (mSt != 0) step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b1);

    // random contests
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a, b;
      bit on;
      a = AW'($urandom);
      b = AW'($urandom);
      if (a == b) b = b ^ 1'b1;
      on = ($urandom_range(0, 4) != 0);
      contest(a, b, on, ($urandom_range(0, 3) == 0));
      drain();
      step(1'b0, '0, 1'b1);
    end
    finishRun();
  end

endmodule